// File: doc/BRIEF.md
# Frame Timing Generator with Phase Select

This block derives the frame strobes of a configurable serializer/deserializer from its high-speed bit clock. A three-bit select code picks the frame ratio n, the number of bit-clock cycles per frame. The divider does nothing until a rising edge arrives on the sync input. It then counts frames, asserts a one-cycle load strobe once per frame and raises a lock flag once its settle window has passed.

A low-speed clock output follows the frame rate, or half of it on request. It can be rotated in eighth-period steps to make up for board trace delays. Several devices lock together when one master's low-speed clock drives the sync input of the others. A free-running frame-rate clock on sync holds the load points in place, because an edge that falls exactly on a frame boundary does not disturb the divider.

Top module: `frame_timing_gen`

## Requirements
- R1: The frame ratio n is 4, 5, 8, 10, 16, 20, 32 or 40 for sel_i codes 000 through 111. Once load pulses start they come every n cycles, each one cycle wide.
- R2: After reset, and until the first rising edge of sync_i, load_o, locked_o and slow_clk_o stay low.
- R3: Let sync_i first be sampled high at clock edge e. The divider restarts at edge e+2, and the cycle after that edge is frame cycle t=0. The first load_o is in cycle t=2n-1, and later ones follow every n cycles.
- R4: locked_o is low from the restart through cycle t=2n-1. It is high from cycle t=2n on.
- R5: A rising edge of sync_i whose restart edge does not fall on a frame boundary realigns the divider. locked_o drops in cycle t=0, and R3 and R4 apply again from the new origin.
- R6: A rising edge whose restart edge coincides with the divider's frame boundary changes nothing. Loads keep their schedule and locked_o stays high.
- R7: Let P be the output period: P=n with divc_i low. Let p be the position in the period of cycle t-1. Then slow_clk_o in cycle t is high when ((p - s) mod P) < floor(P/2), where s is the rotation shift. With phase_sel_i at zero, s=0.
- R8: With divc_i high, P=2n. The position is the frame cycle plus n in every odd frame, counting the frame that starts at t=0 as even.
- R9: phase_sel_i value k sets the rotation shift to s=floor(k*P/8) cycles.
- R10: When n is 5 or 10, phase_sel_i has no effect (s=0).
- R11: Only rising edges of sync_i act. Holding sync_i high or letting it fall leaves loads and locked_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | High-speed bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Frame ratio select code |
| sync_i | input | 1 | Alignment input, rising edge acts |
| divc_i | input | 1 | Halve the low-speed clock rate |
| phase_sel_i | input | 3 | Rotation of the low-speed clock in eighths of its period |
| load_o | output | 1 | One-cycle frame strobe |
| locked_o | output | 1 | Settle window has passed since the last realignment |
| slow_clk_o | output | 1 | Low-speed clock output |

## Verification
The assertions assume that sel_i stays constant while the divider runs; a change of ratio is only safe between a reset and the first sync edge. They also assume that sync_i stays low for at least the synchronizer depth between rising edges. The stimulus changes sel_i, divc_i and phase_sel_i only while the block is in reset. It holds sync_i low for at least four cycles before each new rising edge, and it picks the restart cycle on purpose to land either off or on a frame boundary.

// File: rtl/ftg_pkg.sv
package ftg_pkg;
  parameter int unsigned MAX_N = 40;
  localparam int unsigned CNT_W = $clog2(MAX_N + 1);
  localparam int unsigned PC_W  = $clog2(2 * MAX_N + 1);

  typedef logic [CNT_W-1:0] cnt_t;
  typedef logic [PC_W-1:0]  pc_t;

  function automatic cnt_t ratio_of(input logic [2:0] code);
    case (code)
      3'd0:    return cnt_t'(4);
      3'd1:    return cnt_t'(5);
      3'd2:    return cnt_t'(8);
      3'd3:    return cnt_t'(10);
      3'd4:    return cnt_t'(16);
      3'd5:    return cnt_t'(20);
      3'd6:    return cnt_t'(32);
      default: return cnt_t'(40);
    endcase
  endfunction
endpackage

// File: rtl/ftg_sync_edge.sv
module ftg_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-1:0], d_i};
  end

  assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];

  // R11
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/ftg_divider.sv
module ftg_divider
  import ftg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  cnt_t n_i,
  input  logic rise_i,
  output cnt_t cnt_o,
  output logic half_o,
  output logic run_o,
  output logic load_o,
  output logic locked_o
);
  cnt_t cnt_q;
  logic half_q, seen_q, locked_q, run_q;
  logic wrap, aligned, restart;

  assign wrap    = (cnt_q >= n_i - cnt_t'(1));
  // an edge landing on the frame boundary is already in phase
  assign aligned = run_q && wrap;
  assign restart = rise_i && !aligned;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      half_q   <= 1'b0;
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
      run_q    <= 1'b0;
    end else if (restart) begin
      cnt_q    <= '0;
      half_q   <= 1'b0;
      seen_q   <= 1'b0;
      locked_q <= 1'b0;
      run_q    <= 1'b1;
    end else if (run_q) begin
      if (wrap) begin
        cnt_q  <= '0;
        half_q <= ~half_q;
        seen_q <= 1'b1;
        if (seen_q) locked_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + cnt_t'(1);
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign half_o   = half_q;
  assign run_o    = run_q;
  assign load_o   = run_q && wrap && seen_q;
  assign locked_o = locked_q;

  // R1
  load_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !load_o);

  // R5
  lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_q) |-> $past(rise_i));
endmodule

// File: rtl/ftg_phase_rot.sv
module ftg_phase_rot
  import ftg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  cnt_t       n_i,
  input  cnt_t       cnt_i,
  input  logic       half_i,
  input  logic       divc_i,
  input  logic [2:0] phase_i,
  output logic       slow_o
);
  localparam int unsigned PROD_W = PC_W + 3;

  pc_t              period, pos_raw, shift, pos;
  logic [2:0]       k;
  logic [PROD_W-1:0] prod;
  logic             slow_d, slow_q;

  always_comb begin
    period  = divc_i ? (pc_t'(n_i) << 1) : pc_t'(n_i);
    pos_raw = (divc_i && half_i) ? pc_t'(n_i) + pc_t'(cnt_i) : pc_t'(cnt_i);
    // odd-sized half periods cannot be split into eighths
    k       = (n_i == cnt_t'(5) || n_i == cnt_t'(10)) ? 3'd0 : phase_i;
    prod    = PROD_W'(k) * PROD_W'(period);
    shift   = pc_t'(prod >> 3);
    pos     = (pos_raw >= shift) ? pos_raw - shift : pos_raw + period - shift;
    slow_d  = run_i && (pos < (period >> 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slow_q <= 1'b0;
    else         slow_q <= slow_d;
  end

  assign slow_o = slow_q;
endmodule

// File: rtl/frame_timing_gen.sv
module frame_timing_gen
  import ftg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] sel_i,
  input  logic       sync_i,
  input  logic       divc_i,
  input  logic [2:0] phase_sel_i,
  output logic       load_o,
  output logic       locked_o,
  output logic       slow_clk_o
);
  cnt_t n_sel, cnt;
  logic rise, half, run;

  assign n_sel = ratio_of(sel_i);

  ftg_sync_edge #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (sync_i),
    .rise_o (rise)
  );

  ftg_divider i_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .n_i      (n_sel),
    .rise_i   (rise),
    .cnt_o    (cnt),
    .half_o   (half),
    .run_o    (run),
    .load_o   (load_o),
    .locked_o (locked_o)
  );

  ftg_phase_rot i_rot (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .n_i     (n_sel),
    .cnt_i   (cnt),
    .half_i  (half),
    .divc_i  (divc_i),
    .phase_i (phase_sel_i),
    .slow_o  (slow_clk_o)
  );

  // R4
  lock_after_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !rise) |=> locked_o);
endmodule

// File: tb/test_frame_timing_gen.sv
`timescale 1ns/1ps
module test_frame_timing_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'd0;
  logic       sync_i = 1'b0;
  logic       divc_i = 1'b0;
  logic [2:0] phase_sel_i = 3'd0;
  logic       load_o, locked_o, slow_clk_o;

  frame_timing_gen i_frame_timing_gen (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .sync_i(sync_i),
    .divc_i(divc_i), .phase_sel_i(phase_sel_i),
    .load_o(load_o), .locked_o(locked_o), .slow_clk_o(slow_clk_o)
  );

  always #2 clk_i = ~clk_i;

  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;
  int exp_q[$];
  int g_o = 0, g_n = 4, g_pushed = 0;
  bit g_run = 0;

  task automatic chk(string tag, logic act, logic exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %b expected %b at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  // monitor: pops expected load cycles
  always @(negedge clk_i) begin
    if (rst_ni) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        n_chk++; n_err++;
        $display("FAIL R1,R3 load: got 0 expected 1 at cycle %0d", exp_q.pop_front());
      end
      if (load_o === 1'b1) begin
        n_chk++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) void'(exp_q.pop_front());
        else begin
          n_err++;
          $display("FAIL R1,R3 load: got 1 expected 0 at cycle %0d", cyc);
        end
      end
    end
  end

  task automatic advance(int target);
    for (int j = g_pushed; j <= target; j++)
      if (g_run && j >= g_o + 2*g_n - 1 && ((j - g_o - (2*g_n - 1)) % g_n) == 0)
        exp_q.push_back(j);
    if (target + 1 > g_pushed) g_pushed = target + 1;
    while (cyc < target) @(negedge clk_i);
  endtask

  task automatic start();
    int c, newo;
    c = cyc;
    sync_i = 1'b1;
    newo = c + 3;
    if (g_run && ((newo - g_o) % g_n) == 0) return;
    advance(c);
    for (int j = g_pushed; j <= c + 2; j++)
      if (g_run && j >= g_o + 2*g_n - 1 && ((j - g_o - (2*g_n - 1)) % g_n) == 0)
        exp_q.push_back(j);
    g_o = newo;
    g_pushed = newo;
    g_run = 1;
  endtask

  task automatic do_reset();
    sync_i = 1'b0;
    rst_ni = 1'b0;
    while (exp_q.size() > 0) begin
      n_chk++; n_err++;
      $display("FAIL R1,R3 load: got none expected 1 at cycle %0d", exp_q.pop_front());
    end
    g_run = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    g_pushed = cyc;
  endtask

  function automatic logic exp_slow(int t, int n, logic dv, int k);
    int tm, cn, hf, p, pc, kk, sh, pos;
    tm = t - 1;
    cn = tm % n;
    hf = (tm / n) % 2;
    p  = dv ? 2*n : n;
    pc = (dv && hf == 1) ? n + cn : cn;
    kk = (n == 5 || n == 10) ? 0 : k;
    sh = (kk * p) / 8;
    pos = (pc - sh + p) % p;
    return (pos < p / 2);
  endfunction

  task automatic run_mode(logic [2:0] s, int n, logic dv, logic [2:0] k, string tag);
    int p;
    do_reset();
    sel_i = s; divc_i = dv; phase_sel_i = k; g_n = n;
    advance(cyc + 2);
    start();
    advance(g_o + 2*n - 1);
    chk("R4", locked_o, 1'b0, "locked before window end");
    advance(g_o + 2*n);
    chk("R4", locked_o, 1'b1, "locked after window");
    p = dv ? 2*n : n;
    for (int j = g_o + 2*n + 1; j <= g_o + 2*n + 2*p; j++) begin
      advance(j);
      chk(tag, slow_clk_o, exp_slow(j - g_o, n, dv, int'(k)), "slow clock");
    end
    advance(cyc + n + 1);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion at cycle %0d", cyc);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    do_reset();
    advance(cyc + 2);
    chk("R2", load_o, 1'b0, "load after reset");
    chk("R2", locked_o, 1'b0, "locked after reset");
    chk("R2", slow_clk_o, 1'b0, "slow after reset");
    advance(cyc + 12);
    chk("R2", locked_o, 1'b0, "locked without sync");
    chk("R2", slow_clk_o, 1'b0, "slow without sync");

    run_mode(3'b000, 4, 1'b0, 3'd0, "R7");
    // falling edge and held level do nothing
    sync_i = 1'b0;
    advance(cyc + 6);
    chk("R11", locked_o, 1'b1, "locked after sync fall");
    // off-boundary edge realigns
    while (((cyc + 3 - g_o) % g_n) == 0) advance(cyc + 1);
    start();
    advance(g_o);
    chk("R5", locked_o, 1'b0, "locked on realign");
    advance(g_o + 2*g_n - 1);
    chk("R5", locked_o, 1'b0, "locked before relock");
    advance(g_o + 2*g_n);
    chk("R5", locked_o, 1'b1, "locked after relock");
    advance(cyc + 5);
    sync_i = 1'b0;
    advance(cyc + 5);
    // on-boundary edge is absorbed
    while (((cyc + 3 - g_o) % g_n) != 0) advance(cyc + 1);
    begin
      int c;
      c = cyc;
      start();
      advance(c + 4);
      chk("R6", locked_o, 1'b1, "locked after aligned edge");
      advance(c + 3 * g_n);
      chk("R6", locked_o, 1'b1, "locked later");
    end
    sync_i = 1'b0;

    run_mode(3'b010, 8,  1'b1, 3'd3, "R9");
    run_mode(3'b001, 5,  1'b0, 3'd5, "R10");
    run_mode(3'b111, 40, 1'b0, 3'd2, "R9");
    run_mode(3'b011, 10, 1'b1, 3'd7, "R10");
    run_mode(3'b100, 16, 1'b1, 3'd0, "R8");
    run_mode(3'b101, 20, 1'b0, 3'd1, "R9");
    run_mode(3'b110, 32, 1'b1, 3'd6, "R9");
    do_reset();
    advance(cyc + 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule